// File: doc/BRIEF.md
# Skip/Stuff Polyphase Index Controller

This block steers a polyphase matched filter in a symbol timing loop that updates once per symbol. It holds a fixed-point phase register that spans the whole bank, with IBITS integer bits (M = 2^IBITS branches) and FBITS fraction bits. On each symbol strobe it adds the filtered timing error from the loop filter to the register. The integer part of the register selects the filterbank branch.

When the register rolls past the last branch, the sample clock has gained one sample on the symbol clock. The next sample accepted at the input is then kept away from the filterbank. When the register rolls below branch 0, the sample clock has lost a sample. The last forwarded sample is then sent to the filterbank a second time, and during that cycle the input is held off. Two event counters let a bench or a monitor compare the slip rate with the frequency offset. In steady state, a constant increment of d per symbol gives one slip about every M·2^FBITS/|d| symbols.

Top module: `ssc_index_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, branch_o is 0, skip_o and stuff_o are low, both counters are 0, fb_valid_o is low and in_ready_o is high.
- R2: The phase register changes only in a cycle where sym_en_i is high. It then becomes the sum of the register and the signed loop_err_i, taken modulo M·2^FBITS. In the cycle after the update, branch_o equals the register divided by 2^FBITS, rounded down.
- R3: If that sum is M·2^FBITS or more, skip_o is high for exactly the one cycle that follows the update.
- R4: If that sum is below zero, stuff_o is high for exactly the one cycle that follows the update.
- R5: skip_o and stuff_o are never high together. A sum of exactly 0 or exactly M·2^FBITS−1 produces neither pulse.
- R6: After a skip, the next accepted input sample never appears on fb_data_o.
- R7: After a stuff, in_ready_o is low in the cycle that follows the update. In the next cycle fb_valid_o is high, and fb_data_o repeats the last forwarded sample (0 if no sample has been forwarded yet).
- R8: Outside the cases of R6 and R7, a sample accepted with in_valid_i and in_ready_o both high appears on fb_data_o, with fb_valid_o high, one cycle later.
- R9: skip_cnt_o and stuff_cnt_o each rise by one in the same cycle as the matching pulse, and do not change otherwise.
- R10: A zero loop_err_i leaves branch_o unchanged and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sym_en_i | input | 1 | Symbol strobe; the register is updated in this cycle |
| loop_err_i | input | IBITS+FBITS+1 | Signed loop-filter output, in register LSBs |
| in_valid_i | input | 1 | Input sample valid |
| in_data_i | input | DW | Input sample |
| in_ready_o | output | 1 | Low only during a stuff cycle |
| branch_o | output | IBITS | Polyphase branch index |
| skip_o | output | 1 | One-cycle pulse on overflow |
| stuff_o | output | 1 | One-cycle pulse on underflow |
| fb_valid_o | output | 1 | Sample valid toward the filterbank |
| fb_data_o | output | DW | Sample toward the filterbank |
| skip_cnt_o | output | CW | Skip event count |
| stuff_cnt_o | output | CW | Stuff event count |

## Verification
The hardest situations to reach are the exact wrap edges. These are a register at the top value receiving +1, a register at zero receiving −1, and sums that land exactly on 0 or on the top value without wrapping. A further hard case is a stuff that arrives before any sample has been forwarded. The stimulus walks the register onto each edge with chosen increments. It then sweeps every legal increment value in turn, so the register passes through many wrap and non-wrap sums. Long runs at a constant small offset then produce the periodic slip pattern. A reference model in the bench predicts the sample stream for every one of these runs.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [1:0] {
    SL_IDLE   = 2'd0,
    SL_DROP   = 2'd1,
    SL_REPEAT = 2'd2
  } slip_e;
endpackage

// File: rtl/ssc_phase_acc.sv
module ssc_phase_acc #(
  parameter int IBITS = 5,
  parameter int FBITS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          upd_i,
  input  logic signed [IBITS+FBITS:0]   incr_i,
  output logic [IBITS+FBITS-1:0]        acc_o,
  output logic                          ovf_o,
  output logic                          unf_o
);
  localparam int AW = IBITS + FBITS;

  logic [AW-1:0]        acc_q, acc_d;
  logic signed [AW+1:0] sum_s;

  // Two guard bits: bit AW+1 marks a negative sum, bit AW a sum past the top.
  assign sum_s = $signed({2'b00, acc_q}) + $signed({incr_i[AW], incr_i});

  always_comb begin
    ovf_o = upd_i & ~sum_s[AW+1] & sum_s[AW];
    unf_o = upd_i & sum_s[AW+1];
    acc_d = sum_s[AW-1:0];  // modulo M*2^FBITS, since M is a power of two
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (upd_i) begin
      acc_q <= acc_d;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/ssc_slip_fsm.sv
module ssc_slip_fsm
  import ssc_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ovf_i,
  input  logic          unf_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  output logic          in_ready_o,
  output logic          fb_valid_o,
  output logic [DW-1:0] fb_data_o,
  output logic          skip_o,
  output logic          stuff_o
);
  slip_e         state_q, state_d;
  logic          fbv_q, fbv_d;
  logic [DW-1:0] fbd_q, fbd_d;
  logic [DW-1:0] last_q, last_d;
  logic          fwd;
  logic          data_en;
  logic          skp_q, stf_q;

  assign in_ready_o = (state_q != SL_REPEAT);

  always_comb begin
    state_d = state_q;
    fwd     = 1'b0;
    fbv_d   = 1'b0;
    fbd_d   = fbd_q;
    last_d  = last_q;
    unique case (state_q)
      SL_IDLE: begin
        fwd = in_valid_i;
      end
      SL_DROP: begin
        if (in_valid_i) state_d = SL_IDLE;  // sample discarded here
      end
      SL_REPEAT: begin
        fbv_d   = 1'b1;
        fbd_d   = last_q;
        state_d = SL_IDLE;
      end
      default: state_d = SL_IDLE;
    endcase
    if (fwd) begin
      fbv_d  = 1'b1;
      fbd_d  = in_data_i;
      last_d = in_data_i;
    end
    if (ovf_i) begin
      state_d = SL_DROP;
    end else if (unf_i) begin
      state_d = SL_REPEAT;
    end
  end

  assign data_en = fbv_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SL_IDLE;
      fbv_q   <= 1'b0;
      skp_q   <= 1'b0;
      stf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fbv_q   <= fbv_d;
      skp_q   <= ovf_i;
      stf_q   <= unf_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fbd_q  <= '0;
      last_q <= '0;
    end else if (data_en) begin
      fbd_q  <= fbd_d;
      last_q <= last_d;
    end
  end

  assign fb_valid_o = fbv_q;
  assign fb_data_o  = fbd_q;
  assign skip_o     = skp_q;
  assign stuff_o    = stf_q;
endmodule

// File: rtl/ssc_event_cnt.sv
module ssc_event_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ssc_index_ctrl.sv
module ssc_index_ctrl #(
  parameter int IBITS = 5,
  parameter int FBITS = 8,
  parameter int DW    = 12,
  parameter int CW    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sym_en_i,
  input  logic signed [IBITS+FBITS:0] loop_err_i,
  input  logic                        in_valid_i,
  input  logic [DW-1:0]               in_data_i,
  output logic                        in_ready_o,
  output logic [IBITS-1:0]            branch_o,
  output logic                        skip_o,
  output logic                        stuff_o,
  output logic                        fb_valid_o,
  output logic [DW-1:0]               fb_data_o,
  output logic [CW-1:0]               skip_cnt_o,
  output logic [CW-1:0]               stuff_cnt_o
);
  localparam int AW   = IBITS + FBITS;
  localparam int NEVT = 2;

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [AW-1:0] acc;
  logic          ovf, unf;
  logic [NEVT-1:0] evt;
  logic [CW-1:0] cnt [NEVT];

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  ssc_phase_acc #(.IBITS(IBITS), .FBITS(FBITS)) acc_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .upd_i  (sym_en_i),
    .incr_i (loop_err_i),
    .acc_o  (acc),
    .ovf_o  (ovf),
    .unf_o  (unf)
  );

  assign branch_o = acc[AW-1:FBITS];

  ssc_slip_fsm #(.DW(DW)) fsm_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ovf_i      (ovf),
    .unf_i      (unf),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .in_ready_o (in_ready_o),
    .fb_valid_o (fb_valid_o),
    .fb_data_o  (fb_data_o),
    .skip_o     (skip_o),
    .stuff_o    (stuff_o)
  );

  assign evt = {unf, ovf};

  for (genvar g = 0; g < NEVT; g++) begin : g_cnt
    ssc_event_cnt #(.CW(CW)) cnt_i (
      .clk   (clk),
      .rst_n (rst_int_n),
      .inc_i (evt[g]),
      .cnt_o (cnt[g])
    );
  end

  assign skip_cnt_o  = cnt[0];
  assign stuff_cnt_o = cnt[1];
endmodule

// File: rtl/ssc_index_ctrl_chk.sv
module ssc_index_ctrl_chk #(
  parameter int IBITS = 5,
  parameter int DW    = 12,
  parameter int CW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sym_en_i,
  input logic             in_ready_o,
  input logic [IBITS-1:0] branch_o,
  input logic             skip_o,
  input logic             stuff_o,
  input logic             fb_valid_o,
  input logic [DW-1:0]    fb_data_o,
  input logic [CW-1:0]    skip_cnt_o,
  input logic [CW-1:0]    stuff_cnt_o
);
  a_r2_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_en_i |=> $stable(branch_o));

  a_r5_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(skip_o && stuff_o));

  a_r9_skip_count: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |-> skip_cnt_o == CW'($past(skip_cnt_o) + 1'b1));

  a_r9_stuff_count: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_o |-> stuff_cnt_o == CW'($past(stuff_cnt_o) + 1'b1));

  a_r9_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !skip_o |-> $stable(skip_cnt_o));

  a_r7_repeat_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready_o |=> fb_valid_o && in_ready_o);

  a_r7_stall_on_stuff: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_o |-> !in_ready_o);

  a_r3_skip_single: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |=> !skip_o || $past(sym_en_i));
endmodule

bind ssc_index_ctrl ssc_index_ctrl_chk #(.IBITS(IBITS), .DW(DW), .CW(CW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sym_en_i    (sym_en_i),
  .in_ready_o  (in_ready_o),
  .branch_o    (branch_o),
  .skip_o      (skip_o),
  .stuff_o     (stuff_o),
  .fb_valid_o  (fb_valid_o),
  .fb_data_o   (fb_data_o),
  .skip_cnt_o  (skip_cnt_o),
  .stuff_cnt_o (stuff_cnt_o)
);

// File: tb/ssc_index_ctrl_tb_top.sv
module ssc_index_ctrl_tb_top;
  localparam int IBITS = 3;
  localparam int FBITS = 4;
  localparam int DW    = 8;
  localparam int CW    = 16;
  localparam int RANGE = 1 << (IBITS + FBITS);

  logic                        clk;
  logic                        rst_n;
  logic                        sym_en_i;
  logic signed [IBITS+FBITS:0] loop_err_i;
  logic                        in_valid_i;
  logic [DW-1:0]               in_data_i;
  logic                        in_ready_o;
  logic [IBITS-1:0]            branch_o;
  logic                        skip_o, stuff_o;
  logic                        fb_valid_o;
  logic [DW-1:0]               fb_data_o;
  logic [CW-1:0]               skip_cnt_o, stuff_cnt_o;

  ssc_index_ctrl #(.IBITS(IBITS), .FBITS(FBITS), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sym_en_i(sym_en_i), .loop_err_i(loop_err_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .branch_o(branch_o), .skip_o(skip_o), .stuff_o(stuff_o),
    .fb_valid_o(fb_valid_o), .fb_data_o(fb_data_o),
    .skip_cnt_o(skip_cnt_o), .stuff_cnt_o(stuff_cnt_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  bit mon_on = 0;

  int m_acc = 0, m_skip = 0, m_stuff = 0, last_fwd = 0, seq = 1;
  bit pend_skip = 0;
  int exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Output monitor: every valid beat toward the filterbank must match the model stream.
  always @(negedge clk) begin
    if (mon_on && fb_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6/R8 unexpected beat", int'(fb_data_o), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(fb_data_o) == e, "R6/R7/R8 stream", int'(fb_data_o), e);
      end
    end
  end

  task automatic symbol(input int e, input int nsamp);
    int sum;
    bit ov, un;
    @(negedge clk);
    sym_en_i   = 1'b1;
    loop_err_i = (IBITS+FBITS+1)'(e);
    in_valid_i = 1'b0;
    sum = m_acc + e;
    ov  = (sum >= RANGE);
    un  = (sum < 0);
    m_acc = ((sum % RANGE) + RANGE) % RANGE;
    if (ov) begin m_skip++; pend_skip = 1; end
    if (un) begin m_stuff++; exp_q.push_back(last_fwd); end
    @(negedge clk);
    sym_en_i = 1'b0;
    chk(int'(branch_o) == (m_acc >> FBITS), "R2 branch", int'(branch_o), m_acc >> FBITS);
    chk(skip_o == ov, "R3 skip pulse", int'(skip_o), int'(ov));
    chk(stuff_o == un, "R4 stuff pulse", int'(stuff_o), int'(un));
    chk(!(skip_o && stuff_o), "R5 exclusive", int'(skip_o && stuff_o), 0);
    chk(in_ready_o == !un, "R7 ready", int'(in_ready_o), int'(!un));
    chk(int'(skip_cnt_o) == m_skip, "R9 skip count", int'(skip_cnt_o), m_skip);
    chk(int'(stuff_cnt_o) == m_stuff, "R9 stuff count", int'(stuff_cnt_o), m_stuff);
    for (int i = 0; i < nsamp; i++) begin
      @(negedge clk);
      in_valid_i = 1'b1;
      in_data_i  = DW'(seq);
      if (pend_skip) pend_skip = 0;
      else begin exp_q.push_back(seq & 255); last_fwd = seq & 255; end
      seq = (seq + 1) & 255;
    end
    @(negedge clk);
    in_valid_i = 1'b0;
    chk(skip_o == 1'b0 && stuff_o == 1'b0, "R3/R4 single-cycle pulse",
        int'(skip_o | stuff_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sym_en_i = 1'b0; loop_err_i = '0; in_valid_i = 1'b0; in_data_i = '0;
    repeat (3) @(negedge clk);
    chk(branch_o == 0 && !skip_o && !stuff_o && !fb_valid_o && in_ready_o,
        "R1 in reset", int'(branch_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(branch_o == 0, "R1 branch", int'(branch_o), 0);
    chk(skip_cnt_o == 0 && stuff_cnt_o == 0, "R1 counters", int'(skip_cnt_o + stuff_cnt_o), 0);
    chk(!fb_valid_o && in_ready_o && !skip_o && !stuff_o, "R1 flags", int'(fb_valid_o), 0);
    mon_on = 1;

    // R4/R7: stuff before any sample forwarded repeats 0.
    symbol(-1, 2);
    // R10: zero increments hold the index.
    for (int i = 0; i < 10; i++) symbol(0, 2);
    // Walk onto the edges: R3 wrap from top, R4 wrap from zero, R5 exact limits.
    symbol(-m_acc, 2);          // to 0, no event
    symbol(RANGE - 1, 2);       // to top, no event (R5)
    symbol(1, 3);               // overflow to 0 (R3, R6)
    symbol(-1, 3);              // underflow to top (R4, R7)
    symbol(-(RANGE - 1), 2);    // exactly 0, no event (R5)
    symbol(-RANGE, 2);          // most negative increment, underflow
    // Sweep every legal increment.
    for (int e = -RANGE; e < RANGE; e++) symbol(e, 2);
    // Constant offsets: periodic skips, then periodic stuffs.
    for (int i = 0; i < 300; i++) symbol(1, 1);
    for (int i = 0; i < 300; i++) symbol(-3, 1);
    for (int i = 0; i < 100; i++) symbol(7, 2);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6/R8 stream drained", exp_q.size(), 0);
    chk(int'(skip_cnt_o) == m_skip, "R9 final skips", int'(skip_cnt_o), m_skip);
    chk(int'(stuff_cnt_o) == m_stuff, "R9 final stuffs", int'(stuff_cnt_o), m_stuff);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule